// File: doc/BRIEF.md
# Smart-Card Character Receiver with Programmable Bit Ratio

This block takes one asynchronous serial line and turns each character into a data byte with two error flags. Each character has ten bit times: a low start bit, eight data bits with the least significant first, an even-parity bit, and then a check that the line is high one bit time later. Bit timing comes from a base tick that a prescaler produces from the system clock. A bit lasts a programmable number of base ticks, selected from eight ratios. Some of these ratios are not powers of two (93, 186, 372).

The receiver passes the line through a synchroniser. It waits for a high-to-low transition, starts a per-bit counter at that tick, and samples every bit at the half-period count for the selected ratio. The counter returns to zero at each bit boundary, so the rounding of odd ratios does not build up over the frame. When the check bit has been sampled, the byte and both flags appear together with a single one-cycle strobe. Software must hold the ratio select steady while a frame is being received.

Top module: `scrx_receiver`

## Requirements
- R1: After synchronous reset, `rx_valid_o`, `parity_err_o` and `frame_err_o` are 0 and `rx_data_o` is all zeros.
- R2: The ratio index is `{ratio_hi_i, ratio_lo_i}`. Indices 0 to 7 give a bit length of 32, 64, 372, 256, 93, 128, 186 and 512 base ticks respectively. A frame sent at the selected ratio decodes correctly for every index.
- R3: Counting from the tick that detects the start edge as count 0, each bit is sampled at count floor(N/2)-1, where N is the ratio. A data bit that holds its true value only in the middle half of its bit time is still received correctly.
- R4: A frame begins only on a base tick where the synchronised line is low and was high on the previous tick. The line input goes through two flip-flops before this detection.
- R5: If the line is high again when the start bit is sampled, the receiver drops the event, returns to idle and produces no strobe.
- R6: Data bits arrive least significant bit first. `rx_valid_o` is a one-cycle pulse, and `rx_data_o` holds the byte after the pulse.
- R7: The bit after the data is even parity. If the data ones plus the parity bit give an odd count, `parity_err_o` is 1 in the strobe cycle. The flags are 0 in every other cycle.
- R8: The line is sampled one bit time after the parity bit. If it is low there, `frame_err_o` is 1 in the strobe cycle.
- R9: The per-bit counter reloads to 0 after count N-1 in every bit of a frame. This keeps odd ratios aligned over all ten bits.
- R10: One base tick occurs every `BASE_DIV` system clocks. Bit times are measured in these ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ratio_hi_i | input | 1 | Upper bit of the ratio index |
| ratio_lo_i | input | 2 | Lower two bits of the ratio index |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe that qualifies the byte and both flags |
| parity_err_o | output | 1 | Parity mismatch, valid with the strobe |
| frame_err_o | output | 1 | Check bit found low, valid with the strobe |

## Verification
The parity check and the framing check both resolve in the same strobe cycle. To provoke them together, the bench sends a character that has an inverted parity bit and also holds the line low through the check bit time. The scoreboard expects one strobe that carries the correct byte with both flags set, and it also runs each error on its own to show the two flags do not leak into each other. False starts and edge-corrupted bits at an odd ratio show that the midpoint sample and the per-bit reload work together.

// File: rtl/scrx_pkg.sv
package scrx_pkg;

    localparam int CNT_W = 10;
    localparam int SEL_W = 3;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic perr;
        logic ferr;
    } rx_flags_t;

    function automatic cnt_t ratio_of(input logic [SEL_W-1:0] idx);
        cnt_t r;
        case (idx)
            3'd0:    r = cnt_t'(32);
            3'd1:    r = cnt_t'(64);
            3'd2:    r = cnt_t'(372);
            3'd3:    r = cnt_t'(256);
            3'd4:    r = cnt_t'(93);
            3'd5:    r = cnt_t'(128);
            3'd6:    r = cnt_t'(186);
            default: r = cnt_t'(512);
        endcase
        return r;
    endfunction

    function automatic cnt_t sample_of(input cnt_t period);
        return (period >> 1) - cnt_t'(1);
    endfunction

endpackage

// File: rtl/scrx_line_sync.sv
module scrx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scrx_base_tick.sv
module scrx_base_tick #(
    parameter int BASE_DIV = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    generate
        if (BASE_DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(BASE_DIV);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    div_q <= '0;
                end else if (div_q == DW'(BASE_DIV - 1)) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + DW'(1);
                end
            end
            assign tick_o = (div_q == DW'(BASE_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/scrx_ratio_map.sv
module scrx_ratio_map
    import scrx_pkg::*;
(
    input  logic [SEL_W-1:0] idx_i,
    output cnt_t             period_o,
    output cnt_t             sample_o
);
    always_comb begin
        period_o = ratio_of(idx_i);
        sample_o = sample_of(period_o);
    end
endmodule

// File: rtl/scrx_frame_fsm.sv
module scrx_frame_fsm
    import scrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              line_i,
    input  cnt_t              period_i,
    input  cnt_t              sample_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output rx_flags_t         flags_o,
    output rx_state_e         state_o,
    output cnt_t              cnt_o
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         state_q;
    cnt_t              cnt_q;
    logic [IDX_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_q;
    logic              prev_q;
    logic              at_mid;
    logic              at_end;

    assign at_mid = (cnt_q == sample_i);
    assign at_end = (cnt_q == period_i - cnt_t'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
            prev_q  <= 1'b1;
            data_o  <= '0;
            valid_o <= 1'b0;
            flags_o <= '0;
        end else begin
            valid_o <= 1'b0;
            flags_o <= '0;
            if (tick_i) begin
                prev_q <= line_i;
                if (state_q == ST_IDLE) begin
                    cnt_q <= '0;
                    if (prev_q && !line_i) begin
                        state_q <= ST_START;
                    end
                end else begin
                    cnt_q <= at_end ? '0 : cnt_q + cnt_t'(1);
                    if (at_mid) begin
                        case (state_q)
                            ST_START: begin
                                if (line_i) begin
                                    state_q <= ST_IDLE;
                                    cnt_q   <= '0;
                                end
                            end
                            ST_DATA:   shift_q <= {line_i, shift_q[DATA_W-1:1]};
                            ST_PARITY: par_q   <= line_i;
                            ST_STOP: begin
                                valid_o      <= 1'b1;
                                data_o       <= shift_q;
                                flags_o.perr <= (^shift_q) ^ par_q;
                                flags_o.ferr <= !line_i;
                                state_q      <= ST_IDLE;
                                cnt_q        <= '0;
                            end
                            default: ;
                        endcase
                    end
                    if (at_end) begin
                        case (state_q)
                            ST_START: begin
                                state_q <= ST_DATA;
                                bit_q   <= '0;
                            end
                            ST_DATA: begin
                                if (bit_q == IDX_W'(DATA_W - 1)) begin
                                    state_q <= ST_PARITY;
                                end else begin
                                    bit_q <= bit_q + IDX_W'(1);
                                end
                            end
                            ST_PARITY: state_q <= ST_STOP;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/scrx_receiver.sv
module scrx_receiver
    import scrx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int BASE_DIV = 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ratio_hi_i,
    input  logic [1:0]        ratio_lo_i,
    input  logic              rx_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              parity_err_o,
    output logic              frame_err_o
);
    logic      rx_sync;
    logic      base_tick;
    cnt_t      bit_period;
    cnt_t      mid_point;
    rx_flags_t flags;
    rx_state_e fsm_state;
    cnt_t      fsm_cnt;

    scrx_line_sync #(.STAGES(2)) sync_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (rx_i),
        .q_o   (rx_sync)
    );

    scrx_base_tick #(.BASE_DIV(BASE_DIV)) tick_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (base_tick)
    );

    scrx_ratio_map map_i (
        .idx_i    ({ratio_hi_i, ratio_lo_i}),
        .period_o (bit_period),
        .sample_o (mid_point)
    );

    scrx_frame_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (base_tick),
        .line_i   (rx_sync),
        .period_i (bit_period),
        .sample_i (mid_point),
        .data_o   (rx_data_o),
        .valid_o  (rx_valid_o),
        .flags_o  (flags),
        .state_o  (fsm_state),
        .cnt_o    (fsm_cnt)
    );

    assign parity_err_o = flags.perr;
    assign frame_err_o  = flags.ferr;
endmodule

// File: rtl/scrx_checker.sv
module scrx_checker
    import scrx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      tick,
    input logic      line,
    input rx_state_e state,
    input cnt_t      cnt,
    input cnt_t      period,
    input logic      valid,
    input logic      perr,
    input logic      ferr
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R6

    AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (perr || ferr) |-> valid); // R7

    AST_FERR_FROM_LINE: assert property (@(posedge clk) disable iff (rst)
        ferr |-> $past(!line)); // R8

    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && state != ST_IDLE && state != ST_STOP && cnt == period - cnt_t'(1))
        |=> (cnt == '0)); // R9

    AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (rst)
        (tick && state == ST_START && cnt == sample_of(period) && line)
        |=> (state == ST_IDLE)); // R5

    AST_START_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && $past(state) == ST_IDLE) |-> $past(tick && !line)); // R4
endmodule

bind scrx_receiver scrx_checker chk_i (
    .clk    (clk_i),
    .rst    (rst_i),
    .tick   (base_tick),
    .line   (rx_sync),
    .state  (fsm_state),
    .cnt    (fsm_cnt),
    .period (bit_period),
    .valid  (rx_valid_o),
    .perr   (parity_err_o),
    .ferr   (frame_err_o)
);

// File: tb/scrx_receiver_tb_top.sv
module scrx_receiver_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int DW         = 8;

    typedef struct {
        logic [DW-1:0] data;
        logic          perr;
        logic          ferr;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ratio_hi = 1'b0;
    logic [1:0]    ratio_lo = 2'd0;
    logic          rx_line = 1'b1;
    logic [DW-1:0] rx_data;
    logic          rx_valid;
    logic          perr;
    logic          ferr;

    int checks = 0;
    int errors = 0;
    int seen   = 0;
    int pushed = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    scrx_receiver #(.DATA_W(DW), .BASE_DIV(DIV)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .ratio_hi_i   (ratio_hi),
        .ratio_lo_i   (ratio_lo),
        .rx_i         (rx_line),
        .rx_data_o    (rx_data),
        .rx_valid_o   (rx_valid),
        .parity_err_o (perr),
        .frame_err_o  (ferr)
    );

    function automatic int ref_ratio(input int idx);
        case (idx)
            0: return 32;   1: return 64;   2: return 372;  3: return 256;
            4: return 93;   5: return 128;  6: return 186;  default: return 512;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input bit ragged, input int clks);
        if (ragged) begin
            rx_line = !v; repeat (clks/4) @(negedge clk);
            rx_line = v;  repeat (clks - 2*(clks/4)) @(negedge clk);
            rx_line = !v; repeat (clks/4) @(negedge clk);
        end else begin
            rx_line = v;  repeat (clks) @(negedge clk);
        end
    endtask

    task automatic send_frame(input int idx, input logic [DW-1:0] d, input bit bad_par,
                              input bit low_stop, input bit ragged, input string tag);
        int   clks;
        logic par;
        exp_t e;
        {ratio_hi, ratio_lo} = 3'(idx);
        clks = ref_ratio(idx) * DIV;
        repeat (clks) @(negedge clk);
        par = (^d) ^ bad_par;
        e.data = d; e.perr = bad_par; e.ferr = low_stop; e.tag = tag;
        exp_q.push_back(e);
        pushed++;
        drive_bit(1'b0, 1'b0, clks);
        for (int i = 0; i < DW; i++) drive_bit(d[i], ragged, clks);
        drive_bit(par, ragged, clks);
        drive_bit(!low_stop, 1'b0, clks);
        rx_line = 1'b1;
        repeat (2*clks) @(negedge clk);
    endtask

    task automatic false_start(input int idx);
        int clks;
        {ratio_hi, ratio_lo} = 3'(idx);
        clks = ref_ratio(idx) * DIV;
        rx_line = 1'b0; repeat (clks/4) @(negedge clk);
        rx_line = 1'b1; repeat (3*clks) @(negedge clk);
    endtask

    // monitor: pops expected results as strobes appear
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                seen++;
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5: unexpected strobe, actual data %0h expected none", rx_data);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " data"}, 32'(rx_data), 32'(e.data));
                    check("R7 parity flag", 32'(perr), 32'(e.perr));
                    check("R8 frame flag", 32'(ferr), 32'(e.ferr));
                end
            end else begin
                if (perr || ferr) begin
                    checks++; errors++;
                    $display("FAIL R7: flag without strobe, actual %0b%0b expected 00", perr, ferr);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 valid after reset", 32'(rx_valid), 0);
        check("R1 data after reset", 32'(rx_data), 0);
        check("R1 flags after reset", 32'({perr, ferr}), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R6: LSB-first ordering
        send_frame(0, 8'h01, 0, 0, 0, "R6 lsb");
        send_frame(0, 8'h80, 0, 0, 0, "R6 msb");
        // R6: data held after strobe
        check("R6 data held", 32'(rx_data), 32'h80);
        // R2 / R9 / R10: every ratio index
        for (int i = 0; i < 8; i++) send_frame(i, 8'(8'h3C + 17*i), 0, 0, 0, "R2 ratio");
        // R3: bits only valid in the middle half, odd and even ratios
        send_frame(4, 8'hA5, 0, 0, 1, "R3 ragged odd");
        send_frame(0, 8'h5A, 0, 0, 1, "R3 ragged even");
        // R9: odd ratio, long run of alternating bits
        send_frame(6, 8'h55, 0, 0, 0, "R9 odd reload");
        // R7, R8 alone and together
        send_frame(0, 8'hC3, 1, 0, 0, "R7 parity");
        send_frame(0, 8'h7E, 0, 1, 0, "R8 framing");
        send_frame(4, 8'h96, 1, 1, 0, "R7 R8 both");
        // R5 / R4: glitch on the line is dropped; next frame still decodes
        false_start(0);
        false_start(4);
        send_frame(0, 8'hE1, 0, 0, 0, "R4 after glitch");

        repeat (200) @(negedge clk);
        check("R5 pending results", 32'(exp_q.size()), 0);
        check("R5 strobe count", 32'(seen), 32'(pushed));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule